// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block holds the 10-bit program counter of a small 8-bit microcontroller and the hardware stack of return addresses that goes with it. The current counter value is the program ROM address. Each instruction cycle is marked by a clock enable. In that cycle the instruction decoder raises at most a few control strobes. The sequencer then picks one update: step to the next word, jump, call, return, take an interrupt, add the accumulator to the counter, or load the accumulator into the counter. One program page of 1024 words is addressed. Address 000h is the reset entry and address 008h is the interrupt entry.

Any computed write to the counter from the accumulator forces the two top counter bits to zero, so computed jumps stay inside the first 256 words. Calls and interrupts push return addresses onto a five-entry circular stack. Returns pop them. The block also raises a flag for the pipeline whenever the current instruction changes the flow of control, because such an instruction takes a second instruction cycle.

Top module: `prog_seq`

## Requirements
- R1: While reset is applied, and after it is released, the counter reads 000h. Every stack entry is 000h and the stack is empty.
- R2: When the cycle enable is low, the counter and the stack keep their values, whatever the strobes are.
- R3: An increment with no other strobe adds one to the counter, and 3FFh wraps to 000h.
- R4: A jump loads the counter with the 10-bit immediate.
- R5: A call loads the counter with the immediate and pushes the counter plus one (modulo 1024).
- R6: A return (plain, with a literal, or from an interrupt) loads the counter from the newest stack entry and pops that entry.
- R7: An interrupt entry pushes the current counter value and loads 008h.
- R8: Add-accumulator sets the counter to {2'b00, (counter[7:0] + acc) mod 256}.
- R9: Move-accumulator sets the counter to {2'b00, acc}.
- R10: When several strobes are high at once, the priority is interrupt > return > call > jump > add > move > increment. With no strobe high, the counter holds.
- R11: The extra-cycle output is high exactly when any of jump, call, return, interrupt, add or move is high, independent of the cycle enable.
- R12: The stack is a circular buffer of five entries. A sixth push overwrites the oldest entry. A pop from an empty stack returns the entry one position below the pointer (modulo 5) and moves the pointer to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cyc_en | input | 1 | Instruction-cycle enable |
| inc_i | input | 1 | Sequential increment strobe |
| jmp_i | input | 1 | Jump strobe |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return strobe |
| irq_i | input | 1 | Interrupt entry strobe |
| add_acc_i | input | 1 | Add accumulator to counter strobe |
| mov_acc_i | input | 1 | Load accumulator into counter strobe |
| imm_i | input | 10 | Immediate target address |
| acc_i | input | 8 | Accumulator value |
| pc_o | output | 10 | Current counter value, used as the ROM address |
| stall_o | output | 1 | Current instruction needs an extra cycle |

## Verification
The hardest state to reach from the ports is a stack that has wrapped: six or more pushes in a row without a pop, followed by more pops than there are live entries. Random strobes almost never produce that order. A directed run therefore issues six calls in a row and then six returns, with the counter starting near 3FFh so that the pushed return addresses also wrap. Random stimulus then mixes calls, returns, interrupts and disabled cycles at comparable rates, so the pointer crosses both ends of the buffer many times. Every popped value is compared against a model of the circular stack.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_INC  = 3'd1,
    OP_JMP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_IRQ  = 3'd5,
    OP_ADD  = 3'd6,
    OP_MOV  = 3'd7
  } pc_op_e;
endpackage

// File: rtl/pc_op_sel.sv
module pc_op_sel
  import prog_seq_pkg::*;
(
  input  logic   inc_i,
  input  logic   jmp_i,
  input  logic   call_i,
  input  logic   ret_i,
  input  logic   irq_i,
  input  logic   add_acc_i,
  input  logic   mov_acc_i,
  output pc_op_e op_o,
  output logic   stall_o
);
  always_comb begin
    if (irq_i)          op_o = OP_IRQ;
    else if (ret_i)     op_o = OP_RET;
    else if (call_i)    op_o = OP_CALL;
    else if (jmp_i)     op_o = OP_JMP;
    else if (add_acc_i) op_o = OP_ADD;
    else if (mov_acc_i) op_o = OP_MOV;
    else if (inc_i)     op_o = OP_INC;
    else                op_o = OP_HOLD;
  end

  assign stall_o = !(op_o inside {OP_HOLD, OP_INC});
endmodule

// File: rtl/pc_next_calc.sv
module pc_next_calc
  import prog_seq_pkg::*;
#(
  parameter int unsigned PC_W    = 10,
  parameter int unsigned ACC_W   = 8,
  parameter int unsigned IRQ_VEC = 8
) (
  input  pc_op_e            op_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [PC_W-1:0]   imm_i,
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [PC_W-1:0]   top_i,
  output logic [PC_W-1:0]   pc_nxt_o,
  output logic              push_o,
  output logic              pop_o,
  output logic [PC_W-1:0]   push_val_o
);
  localparam int unsigned HI_W = PC_W - ACC_W;

  logic [ACC_W-1:0] low_sum;

  assign low_sum = pc_i[ACC_W-1:0] + acc_i;

  always_comb begin
    pc_nxt_o   = pc_i;
    push_o     = 1'b0;
    pop_o      = 1'b0;
    push_val_o = pc_i + PC_W'(1);
    unique case (op_i)
      OP_INC:  pc_nxt_o = pc_i + PC_W'(1);
      OP_JMP:  pc_nxt_o = imm_i;
      OP_CALL: begin
        pc_nxt_o = imm_i;
        push_o   = 1'b1;
      end
      OP_RET: begin
        pc_nxt_o = top_i;
        pop_o    = 1'b1;
      end
      OP_IRQ: begin
        pc_nxt_o   = PC_W'(IRQ_VEC);
        push_o     = 1'b1;
        push_val_o = pc_i;
      end
      OP_ADD:  pc_nxt_o = {{HI_W{1'b0}}, low_sum};
      OP_MOV:  pc_nxt_o = {{HI_W{1'b0}}, acc_i};
      default: pc_nxt_o = pc_i;
    endcase
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int unsigned WIDTH = 10,
  parameter int unsigned DEPTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] push_data_i,
  output logic [WIDTH-1:0] top_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d, ptr_inc, ptr_dec;
  logic [WIDTH-1:0] ent_q [DEPTH];

  assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + PTR_W'(1);
  assign ptr_dec = (ptr_q == '0) ? LAST : ptr_q - PTR_W'(1);
  assign top_o   = ent_q[ptr_dec];

  always_comb begin
    ptr_d = ptr_q;
    if (en_i && push_i)     ptr_d = ptr_inc;
    else if (en_i && pop_i) ptr_d = ptr_dec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ent_q[g] <= '0;
      else if (en_i && push_i && (ptr_q == PTR_W'(g)))
        ent_q[g] <= push_data_i;
    end
  end

  // R12
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= LAST);

  // R5
  push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && push_i) |=> (top_o == $past(push_data_i)));

  // R2
  idle_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(ptr_q));
endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import prog_seq_pkg::*;
#(
  parameter int unsigned PC_W      = 10,
  parameter int unsigned ACC_W     = 8,
  parameter int unsigned STK_DEPTH = 5,
  parameter int unsigned RST_VEC   = 0,
  parameter int unsigned IRQ_VEC   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              inc_i,
  input  logic              jmp_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic              irq_i,
  input  logic              add_acc_i,
  input  logic              mov_acc_i,
  input  logic [PC_W-1:0]   imm_i,
  input  logic [ACC_W-1:0]  acc_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              stall_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  pc_op_e           op;
  logic [PC_W-1:0]  pc_q, pc_d, pc_nxt, top, push_val;
  logic             push, pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pc_op_sel u_sel (
    .inc_i(inc_i), .jmp_i(jmp_i), .call_i(call_i), .ret_i(ret_i),
    .irq_i(irq_i), .add_acc_i(add_acc_i), .mov_acc_i(mov_acc_i),
    .op_o(op), .stall_o(stall_o)
  );

  pc_next_calc #(.PC_W(PC_W), .ACC_W(ACC_W), .IRQ_VEC(IRQ_VEC)) u_calc (
    .op_i(op), .pc_i(pc_q), .imm_i(imm_i), .acc_i(acc_i), .top_i(top),
    .pc_nxt_o(pc_nxt), .push_o(push), .pop_o(pop), .push_val_o(push_val)
  );

  ret_stack #(.WIDTH(PC_W), .DEPTH(STK_DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_int_n), .en_i(cyc_en), .push_i(push),
    .pop_i(pop), .push_data_i(push_val), .top_o(top)
  );

  always_comb begin
    pc_d = pc_q;
    if (cyc_en) pc_d = pc_nxt;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pc_q <= PC_W'(RST_VEC);
    else            pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  // R2
  hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cyc_en |=> $stable(pc_o));

  // R7
  irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cyc_en && irq_i) |=> (pc_o == PC_W'(IRQ_VEC)));

  // R4
  jmp_load_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cyc_en && jmp_i && !irq_i && !ret_i && !call_i) |=> (pc_o == $past(imm_i)));

  // R8
  add_clr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cyc_en && add_acc_i && !irq_i && !ret_i && !call_i && !jmp_i)
      |=> (pc_o[PC_W-1:ACC_W] == '0));

  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cyc_en && inc_i && !stall_o) |=> (pc_o == $past(pc_o) + PC_W'(1)));
endmodule

// File: tb/prog_seq_tb_top.sv
`timescale 1ns/1ps
module prog_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_en, inc_i, jmp_i, call_i, ret_i, irq_i, add_acc_i, mov_acc_i;
  logic [9:0] imm_i;
  logic [7:0] acc_i;
  logic [9:0] pc_o;
  logic       stall_o;

  int n_chk = 0;
  int n_fail = 0;

  logic [9:0] m_pc;
  logic [9:0] m_stk [5];
  int         m_ptr;

  always #5 clk = ~clk;

  prog_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .inc_i(inc_i), .jmp_i(jmp_i),
    .call_i(call_i), .ret_i(ret_i), .irq_i(irq_i), .add_acc_i(add_acc_i),
    .mov_acc_i(mov_acc_i), .imm_i(imm_i), .acc_i(acc_i),
    .pc_o(pc_o), .stall_o(stall_o)
  );

  task automatic check(input string tag, input logic [9:0] got, input logic [9:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic exp_stall(input logic j, c, r, q, a, m);
    return j | c | r | q | a | m;
  endfunction

  task automatic model_push(input logic [9:0] v);
    m_stk[m_ptr] = v;
    m_ptr = (m_ptr + 1) % 5;
  endtask

  task automatic model_pop(output logic [9:0] v);
    m_ptr = (m_ptr + 4) % 5;
    v = m_stk[m_ptr];
  endtask

  task automatic step(input string tag, input logic en, inc, j, c, r, q, a, m,
                      input logic [9:0] imm, input logic [7:0] acc);
    logic [9:0] v;
    @(negedge clk);
    cyc_en = en; inc_i = inc; jmp_i = j; call_i = c; ret_i = r;
    irq_i = q; add_acc_i = a; mov_acc_i = m; imm_i = imm; acc_i = acc;
    #1;
    check("R11 stall", {9'd0, stall_o}, {9'd0, exp_stall(j, c, r, q, a, m)});
    if (en) begin
      if (q) begin model_push(m_pc); m_pc = 10'h008; end
      else if (r) begin model_pop(v); m_pc = v; end
      else if (c) begin model_push(m_pc + 10'd1); m_pc = imm; end
      else if (j) m_pc = imm;
      else if (a) m_pc = {2'b00, m_pc[7:0] + acc};
      else if (m) m_pc = {2'b00, acc};
      else if (inc) m_pc = m_pc + 10'd1;
    end
    @(posedge clk);
    #1;
    check(tag, pc_o, m_pc);
  endtask

  task automatic idle_all;
    cyc_en = 0; inc_i = 0; jmp_i = 0; call_i = 0; ret_i = 0;
    irq_i = 0; add_acc_i = 0; mov_acc_i = 0; imm_i = '0; acc_i = '0;
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd7021;
    void'($urandom(seed));
    idle_all();
    rst_n = 1'b0;
    m_pc = '0; m_ptr = 0;
    for (int i = 0; i < 5; i++) m_stk[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 pc in reset", pc_o, 10'h000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 pc after reset", pc_o, 10'h000);

    // R1 / R12: pop from fresh stack returns reset value, pointer wraps
    step("R12 empty pop", 1, 0, 0, 0, 1, 0, 0, 0, 10'h000, 8'h00);
    step("R3 inc", 1, 1, 0, 0, 0, 0, 0, 0, 10'h000, 8'h00);
    // R2: disabled call changes nothing
    step("R2 hold", 0, 1, 0, 1, 0, 0, 0, 0, 10'h155, 8'h00);
    // R4 then R3 wrap
    step("R4 jmp", 1, 0, 1, 0, 0, 0, 0, 0, 10'h3FF, 8'h00);
    step("R3 wrap", 1, 1, 0, 0, 0, 0, 0, 0, 10'h000, 8'h00);
    step("R4 jmp", 1, 0, 1, 0, 0, 0, 0, 0, 10'h3FD, 8'h00);
    // R5 / R12: six calls overflow the stack, return addresses wrap
    for (int i = 0; i < 6; i++)
      step("R5 call", 1, 0, 0, 1, 0, 0, 0, 0, 10'h3FC + 10'(i), 8'h00);
    for (int i = 0; i < 6; i++)
      step("R6 R12 ret", 1, 0, 0, 0, 1, 0, 0, 0, 10'h000, 8'h00);
    // R8: add clears top bits and wraps low byte
    step("R4 jmp", 1, 0, 1, 0, 0, 0, 0, 0, 10'h2F0, 8'h00);
    step("R8 add", 1, 0, 0, 0, 0, 0, 1, 0, 10'h000, 8'h20);
    // R9
    step("R4 jmp", 1, 0, 1, 0, 0, 0, 0, 0, 10'h3AA, 8'h00);
    step("R9 mov", 1, 0, 0, 0, 0, 0, 0, 1, 10'h000, 8'hC3);
    // R7
    step("R7 irq", 1, 1, 1, 1, 1, 1, 1, 1, 10'h123, 8'h11);
    step("R6 reti", 1, 0, 0, 0, 1, 0, 0, 0, 10'h000, 8'h00);
    // R10 priority chain
    step("R10 ret over call", 1, 1, 1, 1, 1, 0, 1, 1, 10'h0AB, 8'h11);
    step("R10 call over jmp", 1, 1, 1, 1, 0, 0, 1, 1, 10'h0AB, 8'h11);
    step("R10 jmp over add", 1, 1, 1, 0, 0, 0, 1, 1, 10'h1CD, 8'h11);
    step("R10 add over mov", 1, 1, 0, 0, 0, 0, 1, 1, 10'h000, 8'h11);
    step("R10 mov over inc", 1, 1, 0, 0, 0, 0, 0, 1, 10'h000, 8'h77);
    step("R10 none hold", 1, 0, 0, 0, 0, 0, 0, 0, 10'h000, 8'h00);

    for (int n = 0; n < 4000; n++) begin
      logic en, c, r, q, j, a, m;
      en = ($urandom % 8) != 0;
      c  = ($urandom % 6) == 0;
      r  = ($urandom % 6) == 0;
      q  = ($urandom % 20) == 0;
      j  = ($urandom % 10) == 0;
      a  = ($urandom % 12) == 0;
      m  = ($urandom % 12) == 0;
      step("R10 random", en, 1'b1, j, c, r, q, a, m,
           10'($urandom), 8'($urandom));
    end

    @(negedge clk);
    idle_all();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule